// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

This block moves outgoing frames from memory to a byte stream by following a linked chain of transmit descriptors. Software places frames in memory, builds descriptors that point to them, writes the address of the first descriptor into the engine, and sets the start bit in the transmit control register. For each descriptor the engine fetches the buffer one 32-bit word at a time and sends the bytes, lowest byte lane first, on either the line stream or a loopback stream. It then marks the descriptor empty in memory, counts the frame in its status register and moves to the descriptor named by the next pointer.

The walk ends at the first descriptor that is already empty. The engine then raises an underrun flag and clears its own start bit. Software acknowledges frames by writing ones to the status register, which decrements the frame counter. An interrupt output combines the transmit status with four receive status bits from a neighbouring block through an eight-bit mask. A write to the main configuration register with bit 31 set restores every register to its default value and aborts a walk in progress.

Top module: `txdesc_dma`

## Requirements
- R1: After reset, or after a write to the main configuration register (word 0) with bit 31 set, the registers read: main configuration 0x80000000, word 1 0x00007000, word 2 0x40605060, word 3 0x00A1F037, and 0 for transmit control (word 4), descriptor base (word 5), status (word 6) and interrupt mask (word 7).
- R2: A write of bit 0 = 1 to transmit control starts a walk at the descriptor base only when configuration bit 0 (transmit enable) is already set; otherwise the value is stored and no memory access or byte follows.
- R3: A descriptor at address D is three little-endian words: buffer byte address at D, size word at D+4 (bit 31 = empty, bits 10:0 = length, other bits ignored) and next-descriptor address at D+8; the memory port holds each request with a stable address until it is acknowledged and only issues word-aligned addresses.
- R4: For a full descriptor exactly the length in bits 10:0 of bytes is sent, taken from consecutive buffer byte addresses starting at the buffer address (byte k of a word is bits 8k+7:8k); the final byte carries last, and a length of 0 sends nothing.
- R5: With configuration bit 8 set when a descriptor is loaded, its frame goes to the loopback stream; with it clear, to the line stream; the other stream stays idle.
- R6: After each frame the size word at D+4 is written back with bit 31 set and its other bits unchanged, the frame count in status bits 23:16 increments (modulo 256), status bit 0 (sent) is set and the next pointer becomes the current descriptor.
- R7: On loading a descriptor whose size bit 31 is set, the engine stops, sets status bit 1 (underrun) and clears transmit control bit 0, leaving that descriptor unchanged.
- R8: Writing 1 to status bit 0 decrements the count and clears bit 0 when the count becomes zero; writing 1 to status bit 1 clears underrun; other written values do not change the status.
- R9: The descriptor base register (word 5) stores written values with bits 1:0 forced to zero.
- R10: The interrupt register (word 8) reads as mask bits 7:0 AND {receive status bits 3:0, transmit status bits 3:0}; the interrupt output is high exactly when that value is nonzero; writes to word 8 have no effect; mask bits 31:8 read as zero.
- R11: A byte held on either stream while ready is low keeps its valid, data and last unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rx_stat | input | 4 | Receive status bits from the receive side |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| tx_data | output | 8 | Line stream byte |
| tx_valid | output | 1 | Line stream valid |
| tx_last | output | 1 | Line stream final byte of frame |
| tx_ready | input | 1 | Line stream ready |
| lb_data | output | 8 | Loopback stream byte |
| lb_valid | output | 1 | Loopback stream valid |
| lb_last | output | 1 | Loopback stream final byte of frame |
| lb_ready | input | 1 | Loopback stream ready |
| irq | output | 1 | Masked interrupt |

## Verification
A register write lands at the next clock edge, so its effect on reg_rdata and irq is due one cycle later, and the bench reads on the following falling edge. The start write puts the first descriptor request on the memory port in the cycle after it, while each status update (count, sent, underrun, cleared start bit) follows the acknowledge of the write-back or of the empty descriptor's last word by one cycle; because memory and stream stalls are random, the bench does not count cycles for a walk but polls transmit control bit 0 until it drops, then compares memory, captured streams and status. Stream bytes are recorded at the falling edge where the bench grants ready against a stable valid, so each captured byte is one that transfers at the next rising edge.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_ADDR, W_SIZE, W_NEXT, W_FETCH, W_SEND, W_WB
  } walk_t;

  // register word indices
  localparam int RI_CFG   = 0;
  localparam int RI_CFG2  = 1;
  localparam int RI_GAP   = 2;
  localparam int RI_HDX   = 3;
  localparam int RI_TXCTL = 4;
  localparam int RI_DESC  = 5;
  localparam int RI_STAT  = 6;
  localparam int RI_MASK  = 7;
  localparam int RI_IRQ   = 8;

  localparam logic [31:0] DEF_CFG  = 32'h8000_0000;
  localparam logic [31:0] DEF_CFG2 = 32'h0000_7000;
  localparam logic [31:0] DEF_GAP  = 32'h4060_5060;
  localparam logic [31:0] DEF_HDX  = 32'h00A1_F037;

  localparam int CFG_TXEN  = 0;
  localparam int CFG_LOOP  = 8;
  localparam int CFG_SRST  = 31;
  localparam int EMPTY_BIT = 31;

  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] idx);
    return w[8*idx +: 8];
  endfunction

  function automatic logic [7:0] irq_vec(input logic [7:0] mask, input logic [3:0] rx,
                                         input logic [3:0] tx);
    return mask & {rx, tx};
  endfunction

  function automatic logic [31:0] word_align(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction
endpackage

// File: rtl/txd_regs.sv
module txd_regs import txd_pkg::*; #(
  parameter int RA_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [3:0]      rx_stat,
  input  logic            frame_done,
  input  logic            underrun_hit,
  input  logic            busy,
  output logic            start,
  output logic            soft_rst,
  output logic [31:0]     desc_base,
  output logic            loop_sel,
  output logic            irq
);
  localparam int CNT_LSB = 16;

  logic [31:0]      cfg, cfg2, gap, hdx, txctl;
  logic [7:0]       mask;
  logic [CNT_W-1:0] cnt;
  logic             und, sent;
  logic [31:0]      stat_word;
  logic [7:0]       irq_reg;

  function automatic logic hit(input int i);
    return reg_we && (reg_addr == RA_W'(i));
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic inc, input logic dec);
    return c + CNT_W'(inc) - CNT_W'(dec);
  endfunction

  logic dec, clr_und;
  logic [CNT_W-1:0] cnt_nx;

  assign soft_rst = hit(RI_CFG) && reg_wdata[CFG_SRST];
  assign start    = hit(RI_TXCTL) && reg_wdata[0] && cfg[CFG_TXEN] && !busy;
  assign dec      = hit(RI_STAT) && reg_wdata[0];
  assign clr_und  = hit(RI_STAT) && reg_wdata[1];
  assign cnt_nx   = next_count(cnt, frame_done, dec);
  assign desc_base = word_align(txctl_base_q);
  assign loop_sel = cfg[CFG_LOOP];

  logic [31:0] txctl_base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= DEF_CFG; cfg2 <= DEF_CFG2; gap <= DEF_GAP; hdx <= DEF_HDX;
      txctl <= '0; txctl_base_q <= '0; mask <= '0;
      cnt <= '0; und <= 1'b0; sent <= 1'b0;
    end else if (soft_rst) begin
      cfg <= DEF_CFG; cfg2 <= DEF_CFG2; gap <= DEF_GAP; hdx <= DEF_HDX;
      txctl <= '0; txctl_base_q <= '0; mask <= '0;
      cnt <= '0; und <= 1'b0; sent <= 1'b0;
    end else begin
      if (hit(RI_CFG))   cfg <= reg_wdata;
      if (hit(RI_CFG2))  cfg2 <= reg_wdata;
      if (hit(RI_GAP))   gap <= reg_wdata;
      if (hit(RI_HDX))   hdx <= reg_wdata;
      if (hit(RI_DESC))  txctl_base_q <= reg_wdata;
      if (hit(RI_MASK))  mask <= reg_wdata[7:0];
      if (hit(RI_TXCTL)) txctl <= reg_wdata;
      if (underrun_hit)  txctl[0] <= 1'b0;
      cnt <= cnt_nx;
      if (frame_done)                       sent <= 1'b1;
      else if (dec && cnt_nx == '0)         sent <= 1'b0;
      if (underrun_hit)                     und <= 1'b1;
      else if (clr_und)                     und <= 1'b0;
    end
  end

  assign stat_word = (32'(cnt) << CNT_LSB) | {30'b0, und, sent};
  assign irq_reg   = irq_vec(mask, rx_stat, stat_word[3:0]);
  assign irq       = |irq_reg;

  always_comb begin
    case (int'(reg_addr))
      RI_CFG:   reg_rdata = cfg;
      RI_CFG2:  reg_rdata = cfg2;
      RI_GAP:   reg_rdata = gap;
      RI_HDX:   reg_rdata = hdx;
      RI_TXCTL: reg_rdata = txctl;
      RI_DESC:  reg_rdata = desc_base;
      RI_STAT:  reg_rdata = stat_word;
      RI_MASK:  reg_rdata = {24'b0, mask};
      RI_IRQ:   reg_rdata = {24'b0, irq_reg};
      default:  reg_rdata = '0;
    endcase
  end

  // R7: an empty descriptor leaves underrun set and the start bit clear
  assert_underrun_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_hit && !soft_rst |=> und && !txctl[0]);

  // R6: a finished frame sets sent and bumps the count
  assert_frame_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !dec && !soft_rst |=> sent && (cnt == $past(cnt) + CNT_W'(1)));

  // R2: a start request puts the walker to work in the next cycle
  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R10: the interrupt never rises with an all-zero mask
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != 8'h00));
endmodule

// File: rtl/txd_walker.sv
module txd_walker import txd_pkg::*; #(
  parameter int LEN_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abort,
  input  logic [31:0] base,
  input  logic        loop_cfg,
  output logic        busy,
  output logic        frame_done,
  output logic        underrun_hit,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        s_valid,
  output logic [7:0]  s_data,
  output logic        s_last,
  output logic        s_loop,
  input  logic        s_ready
);
  localparam logic [31:0] OFS_SIZE = 32'd4;
  localparam logic [31:0] OFS_NEXT = 32'd8;

  walk_t            st;
  logic [31:0]      cur, nxt, bptr, size_w, word, raw_addr;
  logic [LEN_W-1:0] remain, len;
  logic             lsel, acc, byte_go, final_byte;

  assign acc        = mem_req && mem_ack;
  assign len        = size_w[LEN_W-1:0];
  assign byte_go    = s_valid && s_ready;
  assign final_byte = (remain == LEN_W'(1));

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    raw_addr  = cur;
    mem_wdata = '0;
    case (st)
      W_ADDR:  begin mem_req = 1'b1; raw_addr = cur; end
      W_SIZE:  begin mem_req = 1'b1; raw_addr = cur + OFS_SIZE; end
      W_NEXT:  begin mem_req = 1'b1; raw_addr = cur + OFS_NEXT; end
      W_FETCH: begin mem_req = 1'b1; raw_addr = bptr; end
      W_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        raw_addr  = cur + OFS_SIZE;
        mem_wdata = size_w | (32'd1 << EMPTY_BIT);
      end
      default: ;
    endcase
  end

  assign mem_addr     = word_align(raw_addr);
  assign s_valid      = (st == W_SEND);
  assign s_data       = lane_byte(word, bptr[1:0]);
  assign s_last       = final_byte;
  assign s_loop       = lsel;
  assign busy         = (st != W_IDLE);
  assign frame_done   = (st == W_WB) && acc;
  assign underrun_hit = (st == W_NEXT) && acc && size_w[EMPTY_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; cur <= '0; nxt <= '0; bptr <= '0;
      size_w <= '0; word <= '0; remain <= '0; lsel <= 1'b0;
    end else if (abort) begin
      st <= W_IDLE;
    end else begin
      case (st)
        W_IDLE: if (start) begin cur <= base; st <= W_ADDR; end
        W_ADDR: if (acc) begin bptr <= mem_rdata; st <= W_SIZE; end
        W_SIZE: if (acc) begin size_w <= mem_rdata; st <= W_NEXT; end
        W_NEXT: if (acc) begin
          nxt    <= mem_rdata;
          remain <= len;
          lsel   <= loop_cfg;
          if (size_w[EMPTY_BIT])  st <= W_IDLE;
          else if (len == '0)     st <= W_WB;
          else                    st <= W_FETCH;
        end
        W_FETCH: if (acc) begin word <= mem_rdata; st <= W_SEND; end
        W_SEND: if (byte_go) begin
          bptr   <= bptr + 32'd1;
          remain <= remain - LEN_W'(1);
          if (final_byte)             st <= W_WB;
          else if (bptr[1:0] == 2'b11) st <= W_FETCH;
        end
        W_WB: if (acc) begin cur <= nxt; st <= W_ADDR; end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R3: an unanswered request keeps its address and direction
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !abort |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R11: a stalled byte is held unchanged
  assert_byte_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_ready && !abort |=> s_valid && $stable(s_data) && $stable(s_last));

  // R2: the walker leaves idle only on a start request
  assert_idle_until_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st == W_IDLE && !start |=> st == W_IDLE);
endmodule

// File: rtl/txd_route.sv
module txd_route (
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  input  logic       s_loop,
  output logic       s_ready,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  output logic       tx_last,
  input  logic       tx_ready,
  output logic [7:0] lb_data,
  output logic       lb_valid,
  output logic       lb_last,
  input  logic       lb_ready
);
  assign tx_data  = s_data;
  assign lb_data  = s_data;
  assign tx_last  = s_last && !s_loop;
  assign lb_last  = s_last && s_loop;
  assign tx_valid = s_valid && !s_loop;
  assign lb_valid = s_valid && s_loop;
  assign s_ready  = s_loop ? lb_ready : tx_ready;
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma import txd_pkg::*; #(
  parameter int RA_W  = 6,
  parameter int LEN_W = 11,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [3:0]      rx_stat,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic [7:0]      tx_data,
  output logic            tx_valid,
  output logic            tx_last,
  input  logic            tx_ready,
  output logic [7:0]      lb_data,
  output logic            lb_valid,
  output logic            lb_last,
  input  logic            lb_ready,
  output logic            irq
);
  logic        start, soft_rst, loop_sel, busy, frame_done, underrun_hit;
  logic [31:0] desc_base;
  logic        s_valid, s_last, s_loop, s_ready;
  logic [7:0]  s_data;

  txd_regs #(.RA_W(RA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_stat(rx_stat),
    .frame_done(frame_done), .underrun_hit(underrun_hit), .busy(busy),
    .start(start), .soft_rst(soft_rst), .desc_base(desc_base),
    .loop_sel(loop_sel), .irq(irq)
  );

  txd_walker #(.LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(soft_rst),
    .base(desc_base), .loop_cfg(loop_sel), .busy(busy),
    .frame_done(frame_done), .underrun_hit(underrun_hit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_loop(s_loop), .s_ready(s_ready)
  );

  txd_route u_route (
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_loop(s_loop),
    .s_ready(s_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready), .lb_data(lb_data),
    .lb_valid(lb_valid), .lb_last(lb_last), .lb_ready(lb_ready)
  );

  // R5: a frame never appears on both streams at once
  assert_one_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && lb_valid));
endmodule

// File: tb/sim_txdesc_dma.sv
module sim_txdesc_dma;
  localparam int CLK_PERIOD = 10;
  localparam int RA_W = 6;
  localparam int A_CFG = 0, A_CFG2 = 1, A_GAP = 2, A_HDX = 3, A_TXCTL = 4,
                 A_DESC = 5, A_STAT = 6, A_MASK = 7, A_IRQ = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0] rx_stat = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0] tx_data, lb_data;
  logic tx_valid, tx_last, lb_valid, lb_last, irq;
  logic tx_ready = 1'b0, lb_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdesc_dma #(.RA_W(RA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_stat(rx_stat),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .lb_data(lb_data), .lb_valid(lb_valid), .lb_last(lb_last), .lb_ready(lb_ready),
    .irq(irq)
  );

  logic [31:0] mem [0:1023];
  logic [7:0]  tx_q[$], lb_q[$];
  logic        tx_lq[$], lb_lq[$];
  int          req_seen = 0;
  int          vectors = 0, miscompares = 0;
  logic        rt, rl;

  // memory and stream sinks act on the falling edge
  always @(negedge clk) begin
    if (mem_req) req_seen++;
    if (mem_req && ($urandom_range(3) != 0)) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end else begin
      mem_ack <= 1'b0;
    end
    rt = ($urandom_range(3) != 0);
    rl = ($urandom_range(2) != 0);
    tx_ready <= rt;
    lb_ready <= rl;
    if (tx_valid && rt) begin tx_q.push_back(tx_data); tx_lq.push_back(tx_last); end
    if (lb_valid && rl) begin lb_q.push_back(lb_data); lb_lq.push_back(lb_last); end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = RA_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = RA_W'(a);
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] get_b(input logic [31:0] a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  function automatic logic [31:0] exp_stat(input logic [7:0] c, input logic u, input logic s);
    return {8'h00, c, 14'h0, u, s};
  endfunction

  function automatic logic [7:0] exp_irq(input logic [7:0] m, input logic [3:0] rx,
                                         input logic [3:0] txs);
    return m & {rx, txs};
  endfunction

  logic [7:0] e_cnt = 8'h00;
  logic       e_sent = 1'b0;
  logic       e_und = 1'b0;

  task automatic check_defaults(input string tag);
    logic [31:0] v;
    rd(A_CFG, v);   chk(tag, "config", v, 32'h8000_0000);
    rd(A_CFG2, v);  chk(tag, "config2", v, 32'h0000_7000);
    rd(A_GAP, v);   chk(tag, "gap", v, 32'h4060_5060);
    rd(A_HDX, v);   chk(tag, "half duplex", v, 32'h00A1_F037);
    rd(A_TXCTL, v); chk(tag, "tx control", v, 0);
    rd(A_DESC, v);  chk(tag, "desc base", v, 0);
    rd(A_STAT, v);  chk(tag, "status", v, 0);
    rd(A_MASK, v);  chk(tag, "mask", v, 0);
  endtask

  // build a chain of k descriptors (reverse placement) plus an empty terminator
  task automatic build_chain(input int k, input logic [31:0] base, output logic [31:0] first,
                             output logic [7:0] eb[$], output logic el[$],
                             output logic [31:0] szs[$], output logic [31:0] das[$]);
    logic [31:0] term_sz;
    eb = {}; el = {}; szs = {}; das = {};
    for (int i = 0; i < k; i++) das.push_back(base + 32'(16 * (k - i)));
    term_sz = 32'h8000_0000 | ($urandom & 32'h7FF);
    mem[base[11:2]] = 32'h0000_0500;
    mem[base[11:2] + 1] = term_sz;
    mem[base[11:2] + 2] = $urandom;
    for (int i = 0; i < k; i++) begin
      int len;
      logic [31:0] ba, sz, nx;
      len = (i == 1) ? 1 : $urandom_range(0, 60);
      ba = 32'h400 + 32'(i * 32'h80) + 32'($urandom_range(3));
      sz = ($urandom & 32'h7FFF_F800) | 32'(len);
      nx = (i == k - 1) ? base : das[i + 1];
      for (int w = 0; w < 32; w++) mem[ba[11:2] + w] = $urandom;
      mem[das[i][11:2]] = ba;
      mem[das[i][11:2] + 1] = sz;
      mem[das[i][11:2] + 2] = nx;
      szs.push_back(sz);
      for (int b = 0; b < len; b++) begin
        eb.push_back(get_b(ba + 32'(b)));
        el.push_back(b == len - 1);
      end
    end
    szs.push_back(term_sz);
    das.push_back(base);
    first = (k == 0) ? base : das[0];
  endtask

  task automatic run_chain(input int k, input logic loopb, input logic [31:0] base);
    logic [7:0] eb[$];
    logic el[$];
    logic [31:0] szs[$], das[$], first, v;
    int bad;
    build_chain(k, base, first, eb, el, szs, das);
    wr(A_CFG, loopb ? 32'h101 : 32'h1);
    tx_q = {}; lb_q = {}; tx_lq = {}; lb_lq = {};
    wr(A_DESC, first);
    wr(A_TXCTL, 32'h1);
    for (int t = 0; t < 20000; t++) begin
      rd(A_TXCTL, v);
      if (v[0] == 1'b0) break;
    end
    chk("R7", "start bit cleared at chain end", 32'(v[0]), 0);
    // R4/R5: bytes and last flags on the selected stream only
    if (loopb) begin
      chk("R5", "loopback byte count", lb_q.size(), eb.size());
      chk("R5", "line stream idle in loopback", tx_q.size(), 0);
    end else begin
      chk("R5", "line byte count", tx_q.size(), eb.size());
      chk("R5", "loopback idle in line mode", lb_q.size(), 0);
    end
    bad = 0;
    for (int i = 0; i < eb.size(); i++) begin
      logic [7:0] gb; logic gl;
      gb = loopb ? ((i < lb_q.size()) ? lb_q[i] : 8'hxx) : ((i < tx_q.size()) ? tx_q[i] : 8'hxx);
      gl = loopb ? ((i < lb_lq.size()) ? lb_lq[i] : 1'bx) : ((i < tx_lq.size()) ? tx_lq[i] : 1'bx);
      if (bad == 0 && (gb !== eb[i] || gl !== el[i])) begin
        bad = 1;
        chk("R4", $sformatf("byte %0d data/last", i), {23'h0, gl, gb}, {23'h0, el[i], eb[i]});
      end
    end
    if (bad == 0) chk("R4", "frame bytes and last flags", 0, 0);
    // R6: write-back of every sent descriptor, terminator untouched
    for (int i = 0; i < k; i++)
      chk("R6", $sformatf("size write-back desc %0d", i), mem[das[i][11:2] + 1],
          szs[i] | 32'h8000_0000);
    chk("R7", "empty descriptor untouched", mem[base[11:2] + 1], szs[k]);
    e_cnt = e_cnt + 8'(k);
    if (k > 0) e_sent = 1'b1;
    e_und = 1'b1;
    rd(A_STAT, v);
    chk("R6", "status after chain", v, exp_stat(e_cnt, e_und, e_sent));
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: defaults after reset
    check_defaults("R1");
    #1 chk("R10", "irq low after reset", 32'(irq), 0);

    // R9: base register drops its low two bits
    wr(A_DESC, 32'h0000_0127);
    rd(A_DESC, v); chk("R9", "desc base alignment", v, 32'h0000_0124);
    wr(A_DESC, 32'hFFFF_FFFF);
    rd(A_DESC, v); chk("R9", "desc base all ones", v, 32'hFFFF_FFFC);

    // R2: transmit disabled, start write does nothing
    begin
      logic [7:0] eb[$]; logic el[$]; logic [31:0] szs[$], das[$], first;
      build_chain(2, 32'h100, first, eb, el, szs, das);
      wr(A_CFG, 32'h0);
      tx_q = {}; lb_q = {};
      req_seen = 0;
      wr(A_DESC, first);
      wr(A_TXCTL, 32'h1);
      repeat (40) @(negedge clk);
      chk("R2", "no memory access while disabled", req_seen, 0);
      chk("R2", "no bytes while disabled", tx_q.size() + lb_q.size(), 0);
      chk("R2", "descriptor unchanged", mem[das[0][11:2] + 1], szs[0]);
      rd(A_TXCTL, v); chk("R2", "control value stored", v, 32'h1);
      rd(A_STAT, v);  chk("R2", "status untouched", v, 0);
    end

    // R3..R7: chains of varying length, modes and stalls
    run_chain(3, 1'b0, 32'h100);
    run_chain(1, 1'b1, 32'h180);
    run_chain(0, 1'b0, 32'h200);
    run_chain(4, 1'b1, 32'h240);
    for (int r = 0; r < 4; r++) run_chain($urandom_range(1, 5), 1'($urandom_range(1)), 32'h100);

    // R8: write-one-to-clear
    wr(A_STAT, 32'hFFFF_FFFC);
    rd(A_STAT, v); chk("R8", "zeros in bits 1:0 change nothing", v, exp_stat(e_cnt, e_und, e_sent));
    wr(A_STAT, 32'h2); e_und = 1'b0;
    rd(A_STAT, v); chk("R8", "underrun cleared", v, exp_stat(e_cnt, e_und, e_sent));
    while (e_cnt != 8'h00) begin
      wr(A_STAT, 32'h1);
      e_cnt = e_cnt - 8'd1;
      if (e_cnt == 8'h00) e_sent = 1'b0;
      rd(A_STAT, v); chk("R8", "decrement", v, exp_stat(e_cnt, e_und, e_sent));
    end

    // R10: interrupt masking with the status nibble
    run_chain(1, 1'b0, 32'h100);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] m; logic [3:0] rx; logic [7:0] e;
      m = (i == 0) ? 8'h00 : 8'($urandom);
      rx = 4'($urandom);
      wr(A_MASK, {24'hABCDEF, m});
      @(negedge clk); rx_stat = rx;
      e = exp_irq(m, rx, {2'b00, e_und, e_sent});
      rd(A_IRQ, v);  chk("R10", "irq register", v, {24'h0, e});
      chk("R10", "irq output", 32'(irq), 32'(e != 8'h00));
      wr(A_IRQ, 32'hFFFF_FFFF);
      rd(A_IRQ, v);  chk("R10", "irq register write ignored", v, {24'h0, e});
    end
    rd(A_MASK, v); chk("R10", "mask upper bits read zero", v[31:8], 0);

    // R1: configuration bit 31 restores defaults
    wr(A_CFG2, 32'h1234_5678); wr(A_GAP, 32'h1); wr(A_HDX, 32'h2); wr(A_DESC, 32'h300);
    wr(A_CFG, 32'h8000_0101);
    check_defaults("R1");
    rx_stat = 4'h0;
    summary();
  end
endmodule